// File: doc/BRIEF.md
# Halfword Store Immediate Decoder

This block turns one instruction word into the control fields of an immediate-offset halfword store. It covers four encodings. One is a 32-bit form from the fixed-length instruction set. Three come from the compact set: a 16-bit form with a 5-bit scaled offset, a 32-bit form with a 12-bit offset, and a 32-bit form with an 8-bit offset and P/U/W bits. A select pin chooses which set the word belongs to.

For every word the block reports the following:
- the transfer and base register numbers;
- a zero-extended byte offset;
- the pre-index, add and write-back controls;
- whether the word is not this instruction at all;
- whether it must go to the unprivileged store variant;
- whether the encoding is undefined or unpredictable.

Condition evaluation, register reads and the memory access are done elsewhere.

Words enter through a valid/ready stream and leave through a valid/ready stream. A result register sits between the two streams, so each result appears one cycle after it is accepted. Back-pressure works as follows:
- The upstream side may move a word only when `in_valid` and `in_ready` are both high at a clock edge.
- `in_ready` is high when the result register is empty, or when the downstream side takes the current result in the same cycle.
- While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new word is accepted.

Top module: `hstore_imm_dec`

## Requirements
- R1: With `compact_set`=0, a word is recognised only when all of these hold: [31:28]≠1111, [27:25]=000, [22]=1, [20]=0 and [7:4]=1011. For such a word, base=[19:16], transfer=[15:12], and the offset is {[11:8],[3:0]} zero-extended to 32 bits.
- R2: For a recognised fixed-length word, pre-index=[24], add=[23], and write-back is set when [24]=0 or [21]=1.
- R3: A recognised fixed-length word with [24]=0 and [21]=1 raises only the unprivileged-redirect flag. Every other output is zero.
- R4: With `compact_set`=1 and instr[31:27]=10000, the word is the 16-bit form, held in the upper halfword. Its outputs are:
  - offset = instr[26:22]×2;
  - base = {0,instr[21:19]};
  - transfer = {0,instr[18:16]};
  - pre-index=1, add=1, write-back=0.
  The lower halfword has no effect.
- R5: With `compact_set`=1 and instr[31:20]=111110001010, the outputs are base=[19:16], transfer=[15:12], offset=[11:0], pre-index=1, add=1 and write-back=0. A base of 15 raises undefined.
- R6: With `compact_set`=1, instr[31:20]=111110000010 and [11]=1, the word is the 8-bit form:
  - transfer=[15:12], pre-index=[10], add=[9], write-back=[8], offset=[7:0].
  - P,U,W=1,1,0 raises only the redirect flag, and this takes priority over undefined.
  - A base of 15, or [10]=[8]=0, raises undefined.
- R7: Unpredictable is raised when transfer=15, or when write-back is set and base equals transfer. In the fixed-length form it is also raised when write-back is set and base=15. An undefined word never raises unpredictable.
- R8: A word matching no form raises no-match, and all other outputs are zero. This includes a fixed-length word with [31:28]=1111. In the compact set, a 32-bit form is considered only when [31:27] is 11101, 11110 or 11111.
- R9: `in_ready` = !`out_valid` | `out_ready`. A word accepted at an edge appears with `out_valid` after that edge. A stalled result stays stable. `out_valid` falls after consumption when no new word was accepted.
- R10: In reset, `out_valid`=0, all result outputs are 0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| compact_set | input | 1 | 1 = compact set, 0 = fixed-length set |
| instr | input | 32 | Instruction word (compact: first halfword in [31:16]) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| xfer_reg | output | 4 | Transfer register number |
| base_reg | output | 4 | Base register number |
| byte_off | output | 32 | Zero-extended byte offset |
| pre_index | output | 1 | Address uses the offset |
| add_off | output | 1 | Offset is added (0 = subtracted) |
| write_back | output | 1 | Base is updated |
| no_match | output | 1 | Word is not this instruction |
| unpriv_redirect | output | 1 | Word is the unprivileged variant |
| undef_enc | output | 1 | Encoding is undefined |
| unpred_enc | output | 1 | Encoding is unpredictable |

## Verification
Some behaviours are checked by assertions on every cycle:
- the stream rules: one-cycle latency, a stable result under stall, and no phantom results;
- the exclusivity of no-match and redirect against every other output;
- the rule that an undefined word never raises unpredictable;
- the bound on the offset width.

Only the bench scenarios can show that each form extracts the right fields and scales its offset correctly. They also cover the legality corners: a condition of all ones, base 15, P=W=0, PUW=110 and base equal to transfer. These scenarios compare every result against a decode that the bench computes from the word on its own.

// File: rtl/hsd_pkg.sv
`timescale 1ns/1ps
package hsd_pkg;
  localparam int REG_W  = 4;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic [REG_W-1:0]  xfer;
    logic [REG_W-1:0]  base;
    logic [ADDR_W-1:0] off;
    logic              pre;
    logic              up;
    logic              wb;
    logic              nomatch;
    logic              unpriv;
    logic              undef;
    logic              unpred;
  } hsd_dec_t;
endpackage

// File: rtl/hsd_wide_dec.sv
`timescale 1ns/1ps
// Fixed-length set: one 32-bit form.
module hsd_wide_dec
  import hsd_pkg::*;
(
  input  logic [31:0] word,
  output hsd_dec_t    dec
);
  logic fmt_ok, p_bit, w_bit, wb_c;
  logic [REG_W-1:0] rn_c, rt_c;

  assign p_bit  = word[24];
  assign w_bit  = word[21];
  assign rn_c   = word[19:16];
  assign rt_c   = word[15:12];
  assign wb_c   = !p_bit || w_bit;
  assign fmt_ok = (word[31:28] != 4'hF) && (word[27:25] == 3'b000) &&
                  word[22] && !word[20] && (word[7:4] == 4'b1011);

  always_comb begin
    dec = '0;
    if (!fmt_ok) begin
      dec.nomatch = 1'b1;
    end else if (!p_bit && w_bit) begin
      dec.unpriv = 1'b1;
    end else begin
      dec.base   = rn_c;
      dec.xfer   = rt_c;
      dec.off    = {{(ADDR_W-8){1'b0}}, word[11:8], word[3:0]};
      dec.pre    = p_bit;
      dec.up     = word[23];
      dec.wb     = wb_c;
      dec.unpred = (rt_c == 4'hF) ||
                   (wb_c && ((rn_c == 4'hF) || (rn_c == rt_c)));
    end
  end
endmodule

// File: rtl/hsd_compact_dec.sv
`timescale 1ns/1ps
// Compact set: 16-bit form and two 32-bit forms; first halfword in [31:16].
module hsd_compact_dec
  import hsd_pkg::*;
(
  input  logic [31:0] word,
  output hsd_dec_t    dec
);
  logic [15:0] hw1, hw2;
  logic is_wide, f16, f12, f8;
  logic p_bit, u_bit, w_bit, ud_c;
  logic [REG_W-1:0] rn_w, rt_w;

  assign hw1     = word[31:16];
  assign hw2     = word[15:0];
  assign is_wide = (hw1[15:13] == 3'b111) && (hw1[12:11] != 2'b00);
  assign f16     = !is_wide && (hw1[15:11] == 5'b10000);
  assign f12     = is_wide && (hw1[15:4] == 12'b1111_1000_1010);
  assign f8      = is_wide && (hw1[15:4] == 12'b1111_1000_0010) && hw2[11];
  assign rn_w    = hw1[3:0];
  assign rt_w    = hw2[15:12];
  assign p_bit   = hw2[10];
  assign u_bit   = hw2[9];
  assign w_bit   = hw2[8];

  always_comb begin
    dec  = '0;
    ud_c = 1'b0;
    if (f16) begin
      dec.base = {1'b0, hw1[5:3]};
      dec.xfer = {1'b0, hw1[2:0]};
      dec.off  = {{(ADDR_W-6){1'b0}}, hw1[10:6], 1'b0};
      dec.pre  = 1'b1;
      dec.up   = 1'b1;
    end else if (f12) begin
      ud_c       = (rn_w == 4'hF);
      dec.base   = rn_w;
      dec.xfer   = rt_w;
      dec.off    = {{(ADDR_W-12){1'b0}}, hw2[11:0]};
      dec.pre    = 1'b1;
      dec.up     = 1'b1;
      dec.undef  = ud_c;
      dec.unpred = !ud_c && (rt_w == 4'hF);
    end else if (f8) begin
      if (p_bit && u_bit && !w_bit) begin
        dec.unpriv = 1'b1;
      end else begin
        ud_c       = (rn_w == 4'hF) || (!p_bit && !w_bit);
        dec.base   = rn_w;
        dec.xfer   = rt_w;
        dec.off    = {{(ADDR_W-8){1'b0}}, hw2[7:0]};
        dec.pre    = p_bit;
        dec.up     = u_bit;
        dec.wb     = w_bit;
        dec.undef  = ud_c;
        dec.unpred = !ud_c && ((rt_w == 4'hF) || (w_bit && (rn_w == rt_w)));
      end
    end else begin
      dec.nomatch = 1'b1;
    end
  end
endmodule

// File: rtl/hsd_out_stage.sv
`timescale 1ns/1ps
// Result stage; OUT_REG=1 gives one register of latency, 0 passes through.
module hsd_out_stage
  import hsd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  output logic     in_ready,
  input  hsd_dec_t in_dec,
  output logic     out_valid,
  input  logic     out_ready,
  output hsd_dec_t out_dec
);
  generate
    if (OUT_REG) begin : g_reg
      logic     vld_q;
      hsd_dec_t dec_q;
      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_dec   = dec_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dec_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) dec_q <= in_dec;
        end
      end
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_dec   = in_dec;
    end
  endgenerate
endmodule

// File: rtl/hstore_imm_dec.sv
`timescale 1ns/1ps
module hstore_imm_dec
  import hsd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              compact_set,
  input  logic [31:0]       instr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [REG_W-1:0]  xfer_reg,
  output logic [REG_W-1:0]  base_reg,
  output logic [ADDR_W-1:0] byte_off,
  output logic              pre_index,
  output logic              add_off,
  output logic              write_back,
  output logic              no_match,
  output logic              unpriv_redirect,
  output logic              undef_enc,
  output logic              unpred_enc
);
  hsd_dec_t wide_dec, comp_dec, sel_dec, res_dec;

  hsd_wide_dec u_wide (.word(instr), .dec(wide_dec));
  hsd_compact_dec u_comp (.word(instr), .dec(comp_dec));

  assign sel_dec = compact_set ? comp_dec : wide_dec;

  hsd_out_stage #(.OUT_REG(OUT_REG)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_dec(sel_dec),
    .out_valid(out_valid), .out_ready(out_ready), .out_dec(res_dec)
  );

  assign xfer_reg        = res_dec.xfer;
  assign base_reg        = res_dec.base;
  assign byte_off        = res_dec.off;
  assign pre_index       = res_dec.pre;
  assign add_off         = res_dec.up;
  assign write_back      = res_dec.wb;
  assign no_match        = res_dec.nomatch;
  assign unpriv_redirect = res_dec.unpriv;
  assign undef_enc       = res_dec.undef;
  assign unpred_enc      = res_dec.unpred;
endmodule

// File: rtl/hsd_checker.sv
`timescale 1ns/1ps
module hsd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [3:0]  xfer_reg,
  input logic [3:0]  base_reg,
  input logic [31:0] byte_off,
  input logic        pre_index,
  input logic        add_off,
  input logic        write_back,
  input logic        no_match,
  input logic        unpriv_redirect,
  input logic        undef_enc,
  input logic        unpred_enc
);
  logic [46:0] res;
  assign res = {xfer_reg, base_reg, byte_off, pre_index, add_off, write_back,
                no_match, unpriv_redirect, undef_enc, unpred_enc};

  assert_accept_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res));

  assert_no_phantom_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && (out_ready || !out_valid) |=> !out_valid);

  assert_reset_idle_R10: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_nomatch_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && no_match |-> res == 47'h8);

  assert_redirect_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && unpriv_redirect |-> res == 47'h4);

  assert_undef_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(undef_enc && unpred_enc));

  assert_offset_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> byte_off[31:12] == 20'h0);
endmodule

bind hstore_imm_dec hsd_checker u_hsd_checker (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .xfer_reg(xfer_reg),
  .base_reg(base_reg), .byte_off(byte_off), .pre_index(pre_index),
  .add_off(add_off), .write_back(write_back), .no_match(no_match),
  .unpriv_redirect(unpriv_redirect), .undef_enc(undef_enc),
  .unpred_enc(unpred_enc)
);

// File: tb/test_hstore_imm_dec.sv
`timescale 1ns/1ps
module test_hstore_imm_dec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, compact_set = 1'b0;
  logic [31:0] instr = '0;
  logic in_ready, out_valid;
  logic [3:0] xfer_reg, base_reg;
  logic [31:0] byte_off;
  logic pre_index, add_off, write_back, no_match, unpriv_redirect, undef_enc, unpred_enc;
  logic [46:0] got;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hstore_imm_dec i_hstore_imm_dec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .compact_set(compact_set), .instr(instr), .out_valid(out_valid),
    .out_ready(out_ready), .xfer_reg(xfer_reg), .base_reg(base_reg),
    .byte_off(byte_off), .pre_index(pre_index), .add_off(add_off),
    .write_back(write_back), .no_match(no_match),
    .unpriv_redirect(unpriv_redirect), .undef_enc(undef_enc), .unpred_enc(unpred_enc)
  );

  assign got = {xfer_reg, base_reg, byte_off, pre_index, add_off, write_back,
                no_match, unpriv_redirect, undef_enc, unpred_enc};

  function automatic logic [46:0] ref_dec(input logic cs, input logic [31:0] w);
    logic [3:0] rt, rn; logic [31:0] off;
    logic pi, ad, wb, nm, ur, ud, un;
    logic [15:0] h, l;
    rt = 0; rn = 0; off = 0; pi = 0; ad = 0; wb = 0; nm = 0; ur = 0; ud = 0; un = 0;
    h = w[31:16]; l = w[15:0];
    if (!cs) begin
      if (w[31:28] == 4'hF || w[27:25] != 3'd0 || !w[22] || w[20] || w[7:4] != 4'hB) nm = 1;
      else if (!w[24] && w[21]) ur = 1;
      else begin
        rn = w[19:16]; rt = w[15:12];
        off = 32'(w[11:8]) * 16 + 32'(w[3:0]);
        pi = w[24]; ad = w[23]; wb = !w[24] || w[21];
        un = (rt == 15) || (wb && (rn == 15 || rn == rt));
      end
    end else if (h[15:11] == 5'b11101 || h[15:11] == 5'b11110 || h[15:11] == 5'b11111) begin
      if (h[15:4] == 12'hF8A) begin
        rn = h[3:0]; rt = l[15:12]; off = 32'(l[11:0]); pi = 1; ad = 1;
        ud = (rn == 15); un = !ud && rt == 15;
      end else if (h[15:4] == 12'hF82 && l[11]) begin
        if (l[10:8] == 3'b110) ur = 1;
        else begin
          rn = h[3:0]; rt = l[15:12]; off = 32'(l[7:0]);
          pi = l[10]; ad = l[9]; wb = l[8];
          ud = (rn == 15) || (!l[10] && !l[8]);
          un = !ud && (rt == 15 || (wb && rn == rt));
        end
      end else nm = 1;
    end else if (h[15:11] == 5'b10000) begin
      rn = 4'(h[5:3]); rt = 4'(h[2:0]); off = 32'(h[10:6]) * 2; pi = 1; ad = 1;
    end else nm = 1;
    return {rt, rn, off, pi, ad, wb, nm, ur, ud, un};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [46:0] act, input logic [46:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h out_valid=%0b", tag, act, exp, out_valid);
    end
  endtask

  task automatic xact(input logic cs, input logic [31:0] w, input string tag);
    logic [46:0] exp;
    exp = ref_dec(cs, w);
    @(negedge clk);
    in_valid = 1; compact_set = cs; instr = w; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && got == exp, tag, got, exp);
  endtask

  function automatic logic [32:0] gen(input int kind);
    logic [31:0] w; logic cs;
    w = $urandom; cs = 1;
    case (kind)
      0: begin cs = 0; w[27:25] = 0; w[22] = 1; w[20] = 0; w[7:4] = 4'hB;
               if (w[31:28] == 4'hF) w[31:28] = 4'hE; end
      1: w[31:27] = 5'b10000;
      2: w[31:20] = 12'hF8A;
      3: begin w[31:20] = 12'hF82; w[11] = 1; end
      default: cs = 1'($urandom);
    endcase
    return {cs, w};
  endfunction

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [46:0] ea, eb;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready && got == 0, "R10 reset", got, 47'h0);
    rst_n = 1;
    // directed corners
    xact(0, 32'hE1C3_40BA, "R1 fixed offset pre-index");
    xact(0, 32'hE04F_1AB5, "R2 fixed post-index writeback");
    xact(0, 32'hE06F_1AB5, "R3 fixed redirect");
    xact(0, 32'hF1C3_40BA, "R8 fixed cond all ones");
    xact(0, 32'hE1C3_F0B0, "R7 fixed xfer 15");
    xact(0, 32'hE1EF_20B0, "R7 fixed writeback base 15");
    xact(0, 32'hE1E4_40B0, "R7 fixed writeback base==xfer");
    xact(1, 32'h87FF_1234, "R4 16-bit max offset");
    xact(1, 32'hF8AF_3123, "R5 12-bit base 15 undef");
    xact(1, 32'hF8A2_FFFF, "R5 12-bit xfer 15");
    xact(1, 32'hF822_3E10, "R6 8-bit redirect");
    xact(1, 32'hF82F_3E10, "R6 8-bit redirect over undef");
    xact(1, 32'hF822_3A10, "R6 8-bit P=W=0 undef");
    xact(1, 32'hF825_5D44, "R7 8-bit writeback base==xfer");
    xact(1, 32'hF825_5C44, "R6 8-bit negative offset");
    xact(1, 32'hF822_3610, "R8 8-bit bit11 clear");
    xact(1, 32'hE8A2_3123, "R8 compact prefix 11101 other");
    xact(1, 32'hC8A2_3123, "R8 compact 16-bit other");
    // random
    for (int i = 0; i < 400; i++) begin
      logic [32:0] g; int k;
      k = i % 5;
      g = gen(k);
      xact(g[32], g[31:0], k == 0 ? "R1 R2 fixed random" : k == 1 ? "R4 16-bit random" :
           k == 2 ? "R5 12-bit random" : k == 3 ? "R6 8-bit random" : "R8 any random");
    end
    // back-pressure
    ea = ref_dec(1, 32'hF8A1_2345);
    eb = ref_dec(1, 32'h8123_0000);
    @(negedge clk);
    in_valid = 1; compact_set = 1; instr = 32'hF8A1_2345; out_ready = 0;
    @(negedge clk);
    instr = 32'h8123_0000;
    chk(out_valid && !in_ready && got == ea, "R9 stall first", got, ea);
    repeat (2) begin
      @(negedge clk);
      chk(out_valid && !in_ready && got == ea, "R9 stall hold", got, ea);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid && got == eb, "R9 drain and accept", got, eb);
    @(negedge clk);
    chk(!out_valid && in_ready, "R9 empty after consume", {46'h0, out_valid}, 47'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule